// File: doc/BRIEF.md
# Branch Trace Bus Message Generator

This block turns every taken-branch event into two consecutive special bus cycles. The first cycle reports where the branch left from: the code-segment selector and instruction pointer of the branch source. The second reports where it landed: the target selector and instruction pointer. It also packs the target's operating mode and the default operand size of the target code segment into upper address bits of that second cycle.

An upstream branch unit offers one event at a time with a valid/ready handshake. The block latches the event and presents the two cycles to the bus unit, in order, over a second valid/ready handshake. It takes no new event until both cycles of the current pair have been accepted. A target mode code that has no defined meaning sets a sticky error flag. The cycle pair is still emitted exactly as requested.

Top module: `btm_gen`

## Requirements
- R1: After synchronous reset, `cyc_valid` is 0, `evt_ready` is 1 and `mode_err` is 0.
- R2: One cycle after an event is accepted, `cyc_valid` rises with the source cycle. Its address bit 31 is 0, bits 30:28 are 0, bits 19:4 hold the source selector, and the data word is the source instruction pointer.
- R3: The target cycle has address bit 31 set to 1. Bits 30:29 hold the target mode code (00 real, 10 protected, 11 virtual-8086, 01 invalid). Bit 28 is the operand size (1 = 32-bit, 0 = 16-bit). Bits 19:4 hold the target selector, and the data word is the target instruction pointer.
- R4: Address bits 27:20 and bit 3 are 0 in every presented cycle.
- R5: The target cycle appears in the cycle after the source cycle is accepted. While `cyc_valid` is high and `cyc_ready` is low, the address and data stay unchanged.
- R6: `evt_ready` is low whenever a cycle is pending. An event offered then has no effect on the cycles emitted. `evt_ready` returns high in the cycle after the target cycle is accepted.
- R7: Accepting an event with mode code 01 sets `mode_err` from the next cycle until reset, and its cycle pair is emitted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Branch event offered |
| evt_ready | output | 1 | Block can take an event |
| evt_src_sel | input | 16 | Source code-segment selector |
| evt_src_ip | input | 32 | Source instruction pointer |
| evt_tgt_sel | input | 16 | Target code-segment selector |
| evt_tgt_ip | input | 32 | Target instruction pointer |
| evt_tgt_mode | input | 2 | Target operating mode code |
| evt_tgt_opsz | input | 1 | Target default operand size, 1 = 32-bit |
| cyc_valid | output | 1 | Special cycle request pending |
| cyc_ready | input | 1 | Bus unit accepts the cycle |
| cyc_addr | output | 29 | Address bits 31 down to 3 |
| cyc_data | output | 32 | Data word |
| mode_err | output | 1 | Sticky invalid-mode flag |

## Verification
The assertions assume nothing about `cyc_ready`: the bus unit may stall for any number of cycles. The event payload is only taken to mean something while `evt_valid` is high and `evt_ready` is high. The stimulus therefore draws `cyc_ready` at random on every cycle. It also changes the event payload and `evt_valid` freely, including while a pair is in flight, so that the hold and ignore properties are exercised under real back-pressure. Mode code 01 is withheld until late in the run so that the sticky flag is seen both clear and set.

// File: rtl/btm_pkg.sv
package btm_pkg;

    localparam int SEL_W   = 16;
    localparam int IP_W    = 32;
    localparam int ADDR_HI = 31;
    localparam int ADDR_LO = 3;
    localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;
    localparam int GAP_W   = 8;

    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_BAD  = 2'b01,
        MODE_PROT = 2'b10,
        MODE_V86  = 2'b11
    } tgt_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SRC  = 2'd1,
        PH_TGT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SEL_W-1:0] src_sel;
        logic [IP_W-1:0]  src_ip;
        logic [SEL_W-1:0] tgt_sel;
        logic [IP_W-1:0]  tgt_ip;
        tgt_mode_e        mode;
        logic             opsz;
    } branch_evt_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [IP_W-1:0]   data;
    } bus_cyc_t;

    // Address bits 31..3 laid out MSB first: cycle id, mode, size, gap, selector, spare.
    function automatic logic [ADDR_W-1:0] pack_addr(
        input logic             is_tgt,
        input tgt_mode_e        mode,
        input logic             opsz,
        input logic [SEL_W-1:0] sel
    );
        logic [1:0] m;
        logic       s;
        m = is_tgt ? mode : 2'b00;
        s = is_tgt ? opsz : 1'b0;
        return {is_tgt, m, s, {GAP_W{1'b0}}, sel, 1'b0};
    endfunction

endpackage

// File: rtl/btm_evt_reg.sv
module btm_evt_reg
    import btm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  branch_evt_t evt_d,
    output branch_evt_t evt_q,
    output logic        err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else if (load) begin
            evt_q <= evt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (load && evt_d.mode == MODE_BAD) begin
            err_q <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R7
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        (load && evt_d.mode == MODE_BAD) |=> err_q); // R7
endmodule

// File: rtl/btm_phase_fsm.sv
module btm_phase_fsm
    import btm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_valid,
    input  logic cyc_ready,
    output logic evt_ready,
    output logic load,
    output logic cyc_valid,
    output logic is_tgt
);
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (evt_valid) phase <= PH_SRC;
                PH_SRC:  if (cyc_ready) phase <= PH_TGT;
                PH_TGT:  if (cyc_ready) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        evt_ready = (phase == PH_IDLE);
        cyc_valid = (phase != PH_IDLE);
        is_tgt    = (phase == PH_TGT);
        load      = evt_valid && evt_ready;
    end

    AST_SRC_THEN_TGT: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_ready && !is_tgt) |=> (cyc_valid && is_tgt)); // R5
    AST_FREE_AFTER_TGT: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_ready && is_tgt) |=> evt_ready); // R6
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cyc_valid && !is_tgt)); // R2
endmodule

// File: rtl/btm_cycle_fmt.sv
module btm_cycle_fmt
    import btm_pkg::*;
(
    input  branch_evt_t evt,
    input  logic        is_tgt,
    output bus_cyc_t    cyc
);
    always_comb begin
        if (is_tgt) begin
            cyc.addr = pack_addr(1'b1, evt.mode, evt.opsz, evt.tgt_sel);
            cyc.data = evt.tgt_ip;
        end else begin
            cyc.addr = pack_addr(1'b0, evt.mode, evt.opsz, evt.src_sel);
            cyc.data = evt.src_ip;
        end
    end
endmodule

// File: rtl/btm_gen.sv
module btm_gen
    import btm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_valid,
    output logic                evt_ready,
    input  logic [SEL_W-1:0]    evt_src_sel,
    input  logic [IP_W-1:0]     evt_src_ip,
    input  logic [SEL_W-1:0]    evt_tgt_sel,
    input  logic [IP_W-1:0]     evt_tgt_ip,
    input  logic [1:0]          evt_tgt_mode,
    input  logic                evt_tgt_opsz,
    output logic                cyc_valid,
    input  logic                cyc_ready,
    output logic [ADDR_HI:ADDR_LO] cyc_addr,
    output logic [IP_W-1:0]     cyc_data,
    output logic                mode_err
);
    branch_evt_t evt_in, evt_held;
    bus_cyc_t    cyc;
    logic        load, is_tgt;

    always_comb begin
        evt_in.src_sel = evt_src_sel;
        evt_in.src_ip  = evt_src_ip;
        evt_in.tgt_sel = evt_tgt_sel;
        evt_in.tgt_ip  = evt_tgt_ip;
        evt_in.mode    = tgt_mode_e'(evt_tgt_mode);
        evt_in.opsz    = evt_tgt_opsz;
    end

    btm_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .cyc_ready (cyc_ready),
        .evt_ready (evt_ready),
        .load      (load),
        .cyc_valid (cyc_valid),
        .is_tgt    (is_tgt)
    );

    btm_evt_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .evt_d (evt_in),
        .evt_q (evt_held),
        .err_q (mode_err)
    );

    btm_cycle_fmt u_fmt (
        .evt    (evt_held),
        .is_tgt (is_tgt),
        .cyc    (cyc)
    );

    assign cyc_addr = cyc.addr;
    assign cyc_data = cyc.data;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_data))); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> !evt_ready); // R6
    AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> (cyc_addr[27:20] == 8'h00 && cyc_addr[3] == 1'b0)); // R4
    AST_SRC_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !cyc_addr[31]) |-> (cyc_addr[30:28] == 3'b000)); // R2
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_valid) |-> !cyc_addr[31]); // R5
endmodule

// File: tb/tb_btm_gen.sv
module tb_btm_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [15:0] evt_src_sel = '0;
    logic [31:0] evt_src_ip = '0;
    logic [15:0] evt_tgt_sel = '0;
    logic [31:0] evt_tgt_ip = '0;
    logic [1:0]  evt_tgt_mode = '0;
    logic        evt_tgt_opsz = 1'b0;
    logic        cyc_valid;
    logic        cyc_ready = 1'b0;
    logic [31:3] cyc_addr;
    logic [31:0] cyc_data;
    logic        mode_err;

    int checks = 0;
    int fails = 0;
    bit allow_bad = 1'b0;
    bit running = 1'b0;
    bit done = 1'b0;

    logic [60:0] exp_q[$];
    bit          err_exp = 1'b0;

    always #2 clk = ~clk;

    btm_gen dut (.*);

    function automatic logic [28:0] mk_addr(bit tgt, logic [1:0] m, logic s, logic [15:0] sel);
        return {tgt, tgt ? m : 2'b00, tgt ? s : 1'b0, 8'h00, sel, 1'b0};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model update at each edge, using values held since last negedge
    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            err_exp <= 1'b0;
        end else if (running) begin
            bit fire_evt;
            fire_evt = evt_valid && (exp_q.size() == 0);
            if (cyc_valid && cyc_ready && exp_q.size() > 0) void'(exp_q.pop_front());
            if (fire_evt) begin
                exp_q.push_back({mk_addr(1'b0, evt_tgt_mode, evt_tgt_opsz, evt_src_sel), evt_src_ip});
                exp_q.push_back({mk_addr(1'b1, evt_tgt_mode, evt_tgt_opsz, evt_tgt_sel), evt_tgt_ip});
                if (evt_tgt_mode == 2'b01) err_exp <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (running && !rst) begin
            bit busy;
            busy = exp_q.size() > 0;
            check(cyc_valid == busy, "R5", "cyc_valid", 64'(cyc_valid), 64'(busy));
            check(evt_ready == !busy, "R6", "evt_ready", 64'(evt_ready), 64'(!busy));
            check(mode_err == err_exp, "R7", "mode_err", 64'(mode_err), 64'(err_exp));
            if (cyc_valid && busy) begin
                logic [60:0] e;
                e = exp_q[0];
                check(cyc_addr[31] == e[60], "R5", "cycle order bit", 64'(cyc_addr[31]), 64'(e[60]));
                check(cyc_addr[27:20] == 8'h00 && cyc_addr[3] == 1'b0, "R4", "zero fields",
                      64'(cyc_addr), 64'(e[60:32]));
                if (e[60])
                    check({cyc_addr, cyc_data} == e, "R3", "target cycle", 64'({cyc_addr, cyc_data}), 64'(e));
                else
                    check({cyc_addr, cyc_data} == e, "R2", "source cycle", 64'({cyc_addr, cyc_data}), 64'(e));
            end
        end
    end

    task automatic drive_cycle();
        @(negedge clk);
        #1;
        cyc_ready    = ($urandom_range(0, 2) != 0);
        evt_valid    = ($urandom_range(0, 1) != 0);
        evt_src_sel  = 16'($urandom());
        evt_src_ip   = $urandom();
        evt_tgt_sel  = 16'($urandom());
        evt_tgt_ip   = $urandom();
        evt_tgt_opsz = 1'($urandom());
        evt_tgt_mode = 2'($urandom());
        if (!allow_bad && evt_tgt_mode == 2'b01) evt_tgt_mode = 2'b10;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(cyc_valid == 1'b0, "R1", "cyc_valid after reset", 64'(cyc_valid), 64'(0));
        check(evt_ready == 1'b1, "R1", "evt_ready after reset", 64'(evt_ready), 64'(1));
        check(mode_err == 1'b0, "R1", "mode_err after reset", 64'(mode_err), 64'(0));
        running = 1'b1;
        // R2/R3/R5/R6: random traffic with back-pressure, valid modes only
        for (int i = 0; i < 1500; i++) drive_cycle();
        // R7: allow the invalid mode code
        allow_bad = 1'b1;
        for (int i = 0; i < 1500; i++) drive_cycle();
        // drain
        @(negedge clk);
        #1;
        evt_valid = 1'b0;
        cyc_ready = 1'b1;
        repeat (6) @(negedge clk);
        check(evt_ready == 1'b1, "R6", "ready after drain", 64'(evt_ready), 64'(1));
        check(mode_err == 1'b1, "R7", "sticky error at end", 64'(mode_err), 64'(1));
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule